// File: doc/BRIEF.md
# FIFO Threshold and DMA Control Register

This block is a 32-bit control register and its status logic, sitting between a simple single-cycle register bus and the receive and transmit FIFOs of a serial controller. Each direction has three things: a DMA enable, a self-clearing flush control and a 6-bit trigger threshold. From the FIFO fill levels it produces a one-cycle flush pulse per FIFO, a DMA request line per direction and a level-triggered data-ready status per direction.

The effective trigger level is the stored code plus one. A receive trigger fires when the FIFO holds at least that many entries. A transmit trigger fires when the FIFO has at least that many free slots. When a direction's DMA is enabled, the trigger drives the DMA request and the ready status is held low. When DMA is off, the trigger drives the ready status.

Threshold codes are clamped to the FIFO depth minus one. A threshold write is refused while a transfer is busy, and the refusal sets a sticky error flag.

Top module: `xbc_regs`

## Requirements
- R1: After reset every writable field reads 0: both DMA enables clear, both thresholds at code 0 (level 1). With both FIFOs empty, the first clock after reset gives rx_ready 0, tx_ready 1, both DMA requests 0, both flush outputs 0 and thr_err 0.
- R2: Only byte address 0x94 maps to the register. Bits 31:16 always read 0 and ignore writes. Reads at other addresses return 0, and writes there change nothing.
- R3: Bit 15 is the receive DMA enable. While it is set, rx_dma_req follows the receive trigger and rx_ready is 0. While it is clear, rx_ready follows the trigger and rx_dma_req is 0.
- R4: Bit 14 is the receive flush. Writing 1 drives rx_flush_o high for exactly the one cycle after the write edge. The bit reads as 0 at all times.
- R5: Bits 13:8 hold the receive threshold code c. The receive trigger is true when rx_level >= c+1. The outputs reflect a level change one clock edge later.
- R6: The low byte repeats this layout for transmit: bit 7 is the DMA enable, bit 6 is the flush and bits 5:0 are the threshold code c. The transmit trigger is true when DEPTH - tx_level >= c+1.
- R7: A written threshold code above DEPTH-1 is stored, and reads back, as DEPTH-1.
- R8: While busy_i is high, a write whose (clamped) threshold differs from the stored one leaves that threshold unchanged and sets thr_err_o. thr_err_o then stays high until reset. The DMA enable and flush bits of the same write still take effect.
- R9: In the cycle after a flush pulse, the request and ready outputs of that direction are 0. After that they re-evaluate from the new FIFO level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational) |
| busy_i | input | 1 | Transfer in progress |
| rx_level_i | input | LVL_W | Receive FIFO entries |
| tx_level_i | input | LVL_W | Transmit FIFO entries |
| rx_flush_o | output | 1 | Receive FIFO flush pulse |
| tx_flush_o | output | 1 | Transmit FIFO flush pulse |
| rx_dma_req_o | output | 1 | Receive DMA request |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| rx_ready_o | output | 1 | Receive data-ready status |
| tx_ready_o | output | 1 | Transmit space-ready status |
| thr_err_o | output | 1 | Sticky threshold-write-while-busy error |

## Verification
The hardest case to reach is the one-cycle window after a flush. Here the forced-low outputs must be told apart from the ordinary one-edge lag of the level compare. The bench drives a behavioural FIFO that empties on the flush edge, and it samples the pulse cycle, the forced-low cycle and the recovery cycle separately. Transmit is the sharpest case, because its free space jumps to full. The busy-write case also needs care. The bench first writes an unchanged threshold while busy and expects no error. It then writes a changed one and expects the error plus the side-field update.

// File: rtl/xbc_pkg.sv
package xbc_pkg;
  localparam int THR_W     = 6;
  localparam int REG_W     = 32;
  localparam int RX_LSB    = 8;   // receive byte position
  localparam int TX_LSB    = 0;   // transmit byte position
  localparam int DMA_BIT   = 7;   // within a direction byte
  localparam int FLUSH_BIT = 6;
  localparam int NCH       = 2;   // 0: transmit, 1: receive
endpackage

// File: rtl/xbc_chan.sv
module xbc_chan
  import xbc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [7:0]       wbyte_i,
  input  logic             busy_i,
  input  logic [LVL_W-1:0] count_i,
  output logic [7:0]       field_o,
  output logic             flush_o,
  output logic             req_o,
  output logic             rdy_o,
  output logic             blocked_o
);
  localparam logic [THR_W-1:0] MAX_CODE = THR_W'(DEPTH - 1);

  logic             dma_q, flush_q, hit_q, hit_d;
  logic [THR_W-1:0] thr_q, thr_sat;

  assign thr_sat   = (wbyte_i[THR_W-1:0] > MAX_CODE) ? MAX_CODE : wbyte_i[THR_W-1:0];
  assign blocked_o = wr_i && busy_i && (thr_sat != thr_q);
  assign hit_d     = int'(count_i) >= int'(thr_q) + 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_q   <= 1'b0;
      flush_q <= 1'b0;
      thr_q   <= '0;
      hit_q   <= 1'b0;
    end else begin
      flush_q <= wr_i && wbyte_i[FLUSH_BIT];
      if (wr_i) dma_q <= wbyte_i[DMA_BIT];
      if (wr_i && !busy_i) thr_q <= thr_sat;
      hit_q <= flush_q ? 1'b0 : hit_d;  // mask the stale level in the cycle after a flush
    end
  end

  assign field_o = {dma_q, 1'b0, thr_q};
  assign flush_o = flush_q;
  assign req_o   = hit_q && dma_q;
  assign rdy_o   = hit_q && !dma_q;

  // R3
  ready_low_dma_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_q |-> !rdy_o);
  // R7
  thr_clamped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_q <= MAX_CODE);
  // R8
  thr_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && busy_i) |=> $stable(thr_q));
  // R9
  flush_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_q |=> (!req_o && !rdy_o));
endmodule

// File: rtl/xbc_regs.sv
module xbc_regs
  import xbc_pkg::*;
#(
  parameter int              DEPTH      = 16,
  parameter int              ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'(12'h094),
  parameter int              LVL_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  input  logic              busy_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  output logic              rx_flush_o,
  output logic              tx_flush_o,
  output logic              rx_dma_req_o,
  output logic              tx_dma_req_o,
  output logic              rx_ready_o,
  output logic              tx_ready_o,
  output logic              thr_err_o
);
  logic             hit_addr, wr;
  logic [7:0]       field [NCH];
  logic [NCH-1:0]   flush, req, rdy, blocked;
  logic [LVL_W-1:0] count [NCH];
  logic             err_q;

  assign hit_addr = (bus_addr_i == REG_OFFSET);
  assign wr       = bus_we_i && hit_addr;
  assign count[0] = LVL_W'(DEPTH) - tx_level_i;  // free slots
  assign count[1] = rx_level_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int LSB = (c == 1) ? RX_LSB : TX_LSB;
    xbc_chan #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr),
      .wbyte_i   (bus_wdata_i[LSB+:8]),
      .busy_i    (busy_i),
      .count_i   (count[c]),
      .field_o   (field[c]),
      .flush_o   (flush[c]),
      .req_o     (req[c]),
      .rdy_o     (rdy[c]),
      .blocked_o (blocked[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (|blocked) err_q <= 1'b1;
  end

  assign bus_rdata_o  = hit_addr ? {16'h0, field[1], field[0]} : '0;
  assign rx_flush_o   = flush[1];
  assign tx_flush_o   = flush[0];
  assign rx_dma_req_o = req[1];
  assign tx_dma_req_o = req[0];
  assign rx_ready_o   = rdy[1];
  assign tx_ready_o   = rdy[0];
  assign thr_err_o    = err_q;

  // R2
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[31:16] == 16'h0);
  // R4
  flush_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rdata_o[14] == 1'b0) && (bus_rdata_o[6] == 1'b0));
  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_err_o |=> thr_err_o);
  // R4
  flush_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush_o |-> $past(bus_we_i && hit_addr && bus_wdata_i[14]));
endmodule

// File: tb/xbc_regs_test.sv
module xbc_regs_test;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic [11:0] addr = 12'h094;
  logic we = 0, busy = 0;
  logic [31:0] wdata = 0, rdata;
  logic [LVL_W-1:0] rx_lvl = 0, tx_lvl = 0;
  logic rx_fl, tx_fl, rx_req, tx_req, rx_rdy, tx_rdy, err;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  xbc_regs #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .busy_i(busy),
    .rx_level_i(rx_lvl), .tx_level_i(tx_lvl), .rx_flush_o(rx_fl),
    .tx_flush_o(tx_fl), .rx_dma_req_o(rx_req), .tx_dma_req_o(tx_req),
    .rx_ready_o(rx_rdy), .tx_ready_o(tx_rdy), .thr_err_o(err));

  // behavioural FIFO emptying
  always @(posedge clk) begin
    if (rx_fl) rx_lvl <= 0;
    if (tx_fl) tx_lvl <= 0;
  end

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1;
    @(negedge clk);
    we = 0; addr = 12'h094;
  endtask

  function automatic int clampc(int c);
    return (c > DEPTH - 1) ? DEPTH - 1 : c;
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 rdata", rdata, 0);
    check("R1 rx_ready", rx_rdy, 0);
    check("R1 tx_ready", tx_rdy, 1);
    check("R1 reqs", {rx_req, tx_req, rx_fl, tx_fl, err}, 0);

    // R2 reserved bits and foreign addresses
    wr(12'h094, 32'hFFFF_0000);
    check("R2 reserved", rdata, 0);
    wr(12'h090, 32'h0000_BFBF);
    check("R2 other addr ignored", rdata, 0);
    addr = 12'h090; #1;
    check("R2 other addr reads 0", rdata, 0);
    addr = 12'h094;

    // R5, R7 receive sweep, DMA off
    for (int c = 0; c < 64; c++) begin
      wr(12'h094, 32'(c) << 8);
      check("R7 rx readback", rdata, 32'(clampc(c)) << 8);
      for (int l = 0; l <= DEPTH; l++) begin
        rx_lvl = LVL_W'(l);
        @(negedge clk);
        check("R5 rx_ready", rx_rdy, (l >= clampc(c) + 1) ? 1 : 0);
      end
    end
    // R3 receive DMA on
    for (int c = 0; c < 20; c += 3) begin
      wr(12'h094, 32'h8000 | (32'(c) << 8));
      for (int l = 0; l <= DEPTH; l++) begin
        rx_lvl = LVL_W'(l);
        @(negedge clk);
        check("R3 rx_dma_req", rx_req, (l >= clampc(c) + 1) ? 1 : 0);
        check("R3 rx_ready low", rx_rdy, 0);
      end
    end
    // R6 transmit sweep, DMA off then on
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 64; c += (d == 0) ? 1 : 5) begin
        wr(12'h094, (d == 1 ? 32'h80 : 0) | 32'(c));
        check("R6 tx readback", rdata, (d == 1 ? 32'h80 : 0) | 32'(clampc(c)));
        for (int l = 0; l <= DEPTH; l++) begin
          tx_lvl = LVL_W'(l);
          @(negedge clk);
          check("R6 tx trigger", {tx_req, tx_rdy},
                (DEPTH - l >= clampc(c) + 1) ? (d == 1 ? 2 : 1) : 0);
        end
      end
    end

    // R4 / R9 receive flush
    wr(12'h094, 32'h0300);  // rx code 3, DMA off
    rx_lvl = 10; @(negedge clk);
    check("R9 rx ready before flush", rx_rdy, 1);
    wr(12'h094, 32'h4300);
    check("R4 rx_flush pulse", rx_fl, 1);
    check("R4 flush reads 0", rdata[14], 0);
    @(negedge clk);
    check("R4 rx_flush one cycle", rx_fl, 0);
    check("R9 rx ready forced low", rx_rdy, 0);
    check("R9 rx fifo emptied", rx_lvl, 0);
    @(negedge clk);
    check("R9 rx ready stays low", rx_rdy, 0);

    // R6 / R9 transmit flush
    wr(12'h094, 32'h0005);
    tx_lvl = 14; @(negedge clk);
    check("R9 tx ready before flush", tx_rdy, 0);
    wr(12'h094, 32'h0045);
    check("R6 tx_flush pulse", tx_fl, 1);
    @(negedge clk);
    check("R9 tx ready forced low", tx_rdy, 0);
    check("R6 tx_flush one cycle", tx_fl, 0);
    @(negedge clk);
    check("R9 tx ready recovers", tx_rdy, 1);

    // R8 busy lock
    busy = 1;
    wr(12'h094, 32'h0005);
    check("R8 same thr no error", err, 0);
    wr(12'h094, 32'h8A80);
    check("R8 thr unchanged dma set", rdata, 32'h8080 | 32'h0005);
    check("R8 error set", err, 1);
    busy = 0;
    wr(12'h094, 32'h0A00);
    check("R8 thr written when idle", rdata, 32'h0A00);
    check("R8 error sticky", err, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule